// File: doc/BRIEF.md
# Packed Unsigned Quadword to Double Converter

This block takes a vector of up to eight 64-bit unsigned integers and turns each lane into an IEEE-754 double-precision value. A vector-length code chooses how many lanes take part. Every lane runs through the same scalar stage, replicated once per lane. That stage normalises the integer with a leading-zero count and then rounds it with guard and sticky bits.

Per-lane masking controls whether a lane is converted. A lane that is not converted either keeps the prior destination value (merge) or is written with zero. A single control bit has two meanings. With a register source at full width, it selects an embedded rounding mode in place of the global one. With a memory source, it replicates the low quadword of the source into every lane.

A reserved 4-bit field must read all ones. Any other value raises an undefined-operation flag and leaves the result untouched. All outputs are registered. They appear one cycle after the input strobe, together with an output strobe.

Top module: `uq2dp_vec`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. `result`, `inexact` and `ud_flag` are updated on that same edge.
- R2: A converted lane holding zero yields +0.0 (all zero bits). A converted lane holding a value below 2^53 yields its exact double.
- R3: A converted lane holding a value of 2^53 or more is rounded to 53 significant bits. The rounding mode encodings are 00 = nearest-even, 01 = toward negative infinity, 10 = toward positive infinity, 11 = toward zero. A round-up that overflows the mantissa increments the exponent.
- R4: `vlen_code` 00 selects lanes 0..1, 01 selects lanes 0..3, and 10 or 11 selects lanes 0..7. Lane j uses bits [64*j+63 : 64*j] of both `src_data` and `result`.
- R5: Every result bit at or above 64 × (number of active lanes) is zero.
- R6: An active lane is converted when `mask_off` is 1 or when its bit in `lane_mask` is 1.
- R7: An active lane that is not converted takes its slice of `old_dst` when `zero_mode` is 0, and takes zero when `zero_mode` is 1.
- R8: `emb_rm` is the rounding mode only when `vlen_code` is 10 or 11, `src_is_mem` is 0 and `ctl_bit` is 1. In every other case `glob_rm` applies.
- R9: When `src_is_mem` is 1 and `ctl_bit` is 1, every converted lane uses `src_data[63:0]` as its input.
- R10: `inexact` is the OR of the rounding-loss flags of the converted lanes only.
- R11: When `rsv_field` is not 4'b1111, `ud_flag` is 1, `inexact` is 0 and `result` keeps its previous value. Otherwise `ud_flag` is 0.
- R12: After reset, `out_valid`, `result`, `inexact` and `ud_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_data | input | 512 | Source integer lanes |
| old_dst | input | 512 | Prior destination, used by merge masking |
| lane_mask | input | 8 | Per-lane conversion enables |
| mask_off | input | 1 | 1 = convert every active lane regardless of `lane_mask` |
| zero_mode | input | 1 | 1 = zero masked-off lanes, 0 = merge |
| vlen_code | input | 2 | Vector length: 00 = 128, 01 = 256, 1x = 512 bits |
| src_is_mem | input | 1 | Source comes from memory |
| ctl_bit | input | 1 | Embedded rounding (register source) or broadcast (memory source) |
| emb_rm | input | 2 | Embedded rounding mode |
| glob_rm | input | 2 | Global rounding mode |
| rsv_field | input | 4 | Reserved field, must be 4'b1111 |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Converted vector |
| inexact | output | 1 | Some converted lane lost precision |
| ud_flag | output | 1 | Reserved field violation |

## Verification
The bench drives values just above 2^53, which expose the guard and sticky logic. It uses exact ties, where nearest-even must look at the mantissa LSB. It also uses the all-ones input, whose round-up carries into the exponent. A design that mishandled any of these would be one ULP off, or would produce a mantissa that wraps to the wrong exponent.

Several cases target the dual-purpose control bit. A memory source with that bit set must broadcast lane 0 and keep the global rounding mode. A narrow register source with the bit set must also keep the global mode. A design that swapped the two meanings would produce visibly wrong lanes or the wrong rounding direction.

Masked lanes with inexact inputs check that `inexact` ignores lanes that were not converted. Short vector lengths check that the tail is zeroed even when `old_dst` is full of ones. A bad reserved field checks that `result` holds its old value.

// File: rtl/uq2dp_pkg.sv
package uq2dp_pkg;

  localparam int QW     = 64;
  localparam int MANT_W = 52;
  localparam int EXP_W  = 11;
  localparam int BIAS   = 1023;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_t;

  // number of zeros above the highest set bit; 64 for a zero word
  function automatic logic [6:0] lead_zeros(input logic [QW-1:0] x);
    logic [6:0] n;
    n = 7'd64;
    for (int i = 0; i < QW; i++) begin
      if (x[i]) n = 7'(QW - 1 - i);
    end
    return n;
  endfunction

  // increment decision for a positive magnitude
  function automatic logic want_round_up(input rmode_t rm, input logic lsb,
                                         input logic guard, input logic sticky);
    logic up;
    case (rm)
      RM_NEAR: up = guard & (sticky | lsb);
      RM_UP:   up = guard | sticky;
      default: up = 1'b0;
    endcase
    return up;
  endfunction

endpackage

// File: rtl/uq2dp_rm_sel.sv
module uq2dp_rm_sel
  import uq2dp_pkg::*;
(
  input  logic [1:0] vlen_code,
  input  logic       src_is_mem,
  input  logic       ctl_bit,
  input  logic [1:0] emb_rm,
  input  logic [1:0] glob_rm,
  output rmode_t     rm
);

  logic emb_used;

  assign emb_used = vlen_code[1] & ~src_is_mem & ctl_bit;
  assign rm       = emb_used ? rmode_t'(emb_rm) : rmode_t'(glob_rm);

  always_comb begin
    // R8
    rm_pick_chk: assert (emb_used || (rm == rmode_t'(glob_rm)));
  end

endmodule

// File: rtl/uq2dp_lane_cvt.sv
module uq2dp_lane_cvt
  import uq2dp_pkg::*;
(
  input  logic [QW-1:0] x,
  input  rmode_t        rm,
  output logic [QW-1:0] f,
  output logic          inexact
);

  localparam int GRD = QW - 2 - MANT_W;   // guard bit position after normalising

  logic [6:0]        lz;
  logic [QW-1:0]     norm;
  logic [MANT_W-1:0] mant;
  logic              guard, sticky, rnd_up, is_zero;
  logic [MANT_W:0]   msum;
  logic [EXP_W-1:0]  exp_f;

  assign is_zero = (x == '0);
  assign lz      = lead_zeros(x);
  assign norm    = x << lz[5:0];
  assign mant    = norm[QW-2 -: MANT_W];
  assign guard   = norm[GRD];
  assign sticky  = |norm[GRD-1:0];
  assign rnd_up  = want_round_up(rm, mant[0], guard, sticky);
  assign msum    = {1'b0, mant} + (MANT_W+1)'(rnd_up);
  assign exp_f   = EXP_W'(BIAS + QW - 1 - int'(lz)) + EXP_W'(msum[MANT_W]);

  assign f       = is_zero ? '0 : {1'b0, exp_f, msum[MANT_W-1:0]};
  assign inexact = ~is_zero & (guard | sticky);

  always_comb begin
    // R2
    norm_lead_chk: assert (is_zero || norm[QW-1]);
    // R2
    exact_small_chk: assert (!inexact || (x[QW-1:MANT_W+1] != '0));
  end

endmodule

// File: rtl/uq2dp_lane_sel.sv
module uq2dp_lane_sel
  import uq2dp_pkg::*;
(
  input  logic          active,
  input  logic          lane_en,
  input  logic          zero_mode,
  input  logic [QW-1:0] cvt,
  input  logic [QW-1:0] old,
  output logic [QW-1:0] out,
  output logic          conv
);

  assign conv = active & lane_en;

  always_comb begin
    if (!active)        out = '0;
    else if (lane_en)   out = cvt;
    else if (zero_mode) out = '0;
    else                out = old;
  end

endmodule

// File: rtl/uq2dp_vec.sv
module uq2dp_vec
  import uq2dp_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*QW-1:0] src_data,
  input  logic [LANES*QW-1:0] old_dst,
  input  logic [LANES-1:0]    lane_mask,
  input  logic                mask_off,
  input  logic                zero_mode,
  input  logic [1:0]          vlen_code,
  input  logic                src_is_mem,
  input  logic                ctl_bit,
  input  logic [1:0]          emb_rm,
  input  logic [1:0]          glob_rm,
  input  logic [3:0]          rsv_field,
  output logic                out_valid,
  output logic [LANES*QW-1:0] result,
  output logic                inexact,
  output logic                ud_flag
);

  localparam int VW  = LANES * QW;
  localparam int CNW = $clog2(LANES + 1);

  rmode_t              rm;
  logic                bcast, rsv_bad;
  logic [CNW-1:0]      lanes_act;
  logic [LANES-1:0]    lane_conv, lane_inx;
  logic [VW-1:0]       lane_word;

  assign bcast   = src_is_mem & ctl_bit;
  assign rsv_bad = (rsv_field != 4'b1111);

  always_comb begin
    case (vlen_code)
      2'b00:   lanes_act = CNW'(LANES / 4);
      2'b01:   lanes_act = CNW'(LANES / 2);
      default: lanes_act = CNW'(LANES);
    endcase
  end

  uq2dp_rm_sel u_rm_sel (
    .vlen_code (vlen_code),
    .src_is_mem(src_is_mem),
    .ctl_bit   (ctl_bit),
    .emb_rm    (emb_rm),
    .glob_rm   (glob_rm),
    .rm        (rm)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [QW-1:0] src_j, cvt_j;
    logic          inx_j, act_j;

    assign src_j = bcast ? src_data[QW-1:0] : src_data[j*QW +: QW];
    assign act_j = (CNW'(j) < lanes_act);

    uq2dp_lane_cvt u_cvt (
      .x      (src_j),
      .rm     (rm),
      .f      (cvt_j),
      .inexact(inx_j)
    );

    uq2dp_lane_sel u_sel (
      .active   (act_j),
      .lane_en  (mask_off | lane_mask[j]),
      .zero_mode(zero_mode),
      .cvt      (cvt_j),
      .old      (old_dst[j*QW +: QW]),
      .out      (lane_word[j*QW +: QW]),
      .conv     (lane_conv[j])
    );

    assign lane_inx[j] = inx_j;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      inexact   <= 1'b0;
      ud_flag   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ud_flag <= rsv_bad;
        if (rsv_bad) begin
          inexact <= 1'b0;
        end else begin
          result  <= lane_word;
          inexact <= |(lane_inx & lane_conv);
        end
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R11
  ud_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rsv_bad) |=> ($stable(result) && !inexact && ud_flag));
  // R5
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rsv_bad && vlen_code == 2'b00) |=> (result[VW-1:VW/4] == '0));
  // R10
  inx_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_conv == '0) |=> !inexact);

endmodule

// File: tb/test_uq2dp_vec.sv
`timescale 1ns/1ps
module test_uq2dp_vec;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] src_data = '0, old_dst = '0;
  logic [7:0]   lane_mask = '0;
  logic         mask_off = 1'b0, zero_mode = 1'b0, src_is_mem = 1'b0, ctl_bit = 1'b0;
  logic [1:0]   vlen_code = 2'b10, emb_rm = 2'b00, glob_rm = 2'b00;
  logic [3:0]   rsv_field = 4'hF;
  logic         out_valid, inexact, ud_flag;
  logic [511:0] result;

  int checks = 0, fails = 0, cycles = 0;
  logic [511:0] model_prev = '0;

  always #10 clk = ~clk;

  uq2dp_vec i_uq2dp_vec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_data(src_data),
    .old_dst(old_dst), .lane_mask(lane_mask), .mask_off(mask_off),
    .zero_mode(zero_mode), .vlen_code(vlen_code), .src_is_mem(src_is_mem),
    .ctl_bit(ctl_bit), .emb_rm(emb_rm), .glob_rm(glob_rm), .rsv_field(rsv_field),
    .out_valid(out_valid), .result(result), .inexact(inexact), .ud_flag(ud_flag)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      summary();
    end
  end

  task automatic check(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference scalar conversion, written as a right-shift with remainder
  function automatic logic [63:0] ref_cvt(logic [63:0] x, logic [1:0] rm, output logic inx);
    int msb, sh, e;
    logic [63:0] m, rem, half;
    logic up;
    inx = 1'b0;
    if (x == 0) return 64'd0;
    msb = 63;
    while (!x[msb]) msb--;
    e = msb;
    if (msb <= 52) begin
      m = x << (52 - msb);
    end else begin
      sh   = msb - 52;
      m    = x >> sh;
      rem  = x & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      inx  = (rem != 0);
      case (rm)
        2'b00:   up = (rem > half) || (rem == half && m[0]);
        2'b10:   up = inx;
        default: up = 1'b0;
      endcase
      m = m + 64'(up);
      if (m[53]) begin
        m = m >> 1;
        e++;
      end
    end
    return {1'b0, 11'(e + 1023), m[51:0]};
  endfunction

  task automatic run_op(string tag);
    logic [511:0] exp_res;
    logic exp_inx, li;
    int nl;
    logic [1:0] rmx;
    logic [63:0] sv;
    nl  = (vlen_code == 2'b00) ? 2 : (vlen_code == 2'b01) ? 4 : 8;
    rmx = (vlen_code[1] && !src_is_mem && ctl_bit) ? emb_rm : glob_rm;
    exp_res = '0;
    exp_inx = 1'b0;
    for (int j = 0; j < nl; j++) begin
      if (mask_off || lane_mask[j]) begin
        sv = (src_is_mem && ctl_bit) ? src_data[63:0] : src_data[j*64 +: 64];
        exp_res[j*64 +: 64] = ref_cvt(sv, rmx, li);
        exp_inx |= li;
      end else if (!zero_mode) begin
        exp_res[j*64 +: 64] = old_dst[j*64 +: 64];
      end
    end
    if (rsv_field != 4'hF) begin
      exp_res = model_prev;
      exp_inx = 1'b0;
    end
    model_prev = exp_res;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 out_valid"}, 512'(out_valid), 512'(1));
    check({tag, " result"}, result, exp_res);
    check({tag, " R10 inexact"}, 512'(inexact), 512'(exp_inx));
    check({tag, " R11 ud_flag"}, 512'(ud_flag), 512'(rsv_field != 4'hF));
    @(negedge clk);
    check({tag, " R1 idle"}, 512'(out_valid), 512'(0));
  endtask

  task automatic defaults();
    src_data = '0; old_dst = '0; lane_mask = 8'hFF; mask_off = 1'b1;
    zero_mode = 1'b0; vlen_code = 2'b10; src_is_mem = 1'b0; ctl_bit = 1'b0;
    emb_rm = 2'b00; glob_rm = 2'b00; rsv_field = 4'hF;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R12 reset valid", 512'(out_valid), 512'(0));
    check("R12 reset result", result, '0);
    check("R12 reset flags", 512'({inexact, ud_flag}), 512'(0));

    // R2 zero and exact values
    defaults();
    src_data[63:0] = 64'd0; src_data[127:64] = 64'd1;
    src_data[191:128] = (64'd1 << 53) - 1; src_data[255:192] = 64'd12345;
    run_op("R2 exact");

    // R3 rounding modes on ties, half-ups and all-ones (exponent carry)
    for (int r = 0; r < 4; r++) begin
      defaults();
      glob_rm = 2'(r);
      src_data[63:0]    = (64'd1 << 53) + 1;
      src_data[127:64]  = (64'd1 << 53) + 3;
      src_data[191:128] = 64'hFFFF_FFFF_FFFF_FFFF;
      src_data[255:192] = 64'h8000_0000_0000_0401;
      src_data[319:256] = 64'h0030_0000_0000_0005;
      run_op("R3 rounding");
    end

    // R4/R5 short vectors with merge data full of ones
    for (int v = 0; v < 2; v++) begin
      defaults();
      vlen_code = 2'(v);
      old_dst = {512{1'b1}};
      for (int j = 0; j < 8; j++) src_data[j*64 +: 64] = 64'(j * 1000 + 7);
      run_op("R4 R5 length");
    end

    // R6/R7 merge and zero masking
    defaults();
    mask_off = 1'b0; lane_mask = 8'b1010_0110;
    old_dst = {8{64'hDEAD_BEEF_0123_4567}};
    for (int j = 0; j < 8; j++) src_data[j*64 +: 64] = 64'(j + 1) << 55 | 64'd3;
    run_op("R6 R7 merge");
    zero_mode = 1'b1;
    run_op("R6 R7 zero");

    // R10 inexact only in masked lanes
    defaults();
    mask_off = 1'b0; lane_mask = 8'b0000_0001;
    src_data[63:0] = 64'd5; src_data[127:64] = 64'hFFFF_FFFF_FFFF_FFFF;
    run_op("R10 masked inexact");

    // R8 embedded rounding: used at full width from register, not otherwise
    defaults();
    ctl_bit = 1'b1; emb_rm = 2'b10; glob_rm = 2'b11;
    src_data[63:0] = (64'd1 << 60) + 1; src_data[127:64] = (64'd1 << 60) + 1;
    run_op("R8 embedded");
    vlen_code = 2'b01;
    run_op("R8 narrow");

    // R9 memory broadcast, rounding stays global
    defaults();
    src_is_mem = 1'b1; ctl_bit = 1'b1; emb_rm = 2'b10; glob_rm = 2'b11;
    for (int j = 0; j < 8; j++) src_data[j*64 +: 64] = 64'(j) * 64'h1_0000_0001;
    src_data[63:0] = (64'd1 << 62) + 9;
    run_op("R9 broadcast");

    // R11 reserved field violation keeps previous result
    defaults();
    src_data[63:0] = 64'hFFFF; rsv_field = 4'b0111;
    run_op("R11 reserved");

    // random mix
    for (int n = 0; n < 400; n++) begin
      for (int j = 0; j < 8; j++) begin
        src_data[j*64 +: 64] = {$urandom, $urandom} >> ($urandom % 64);
        old_dst[j*64 +: 64]  = {$urandom, $urandom};
      end
      lane_mask  = 8'($urandom);
      mask_off   = ($urandom % 4 == 0);
      zero_mode  = 1'($urandom);
      vlen_code  = 2'($urandom);
      src_is_mem = 1'($urandom);
      ctl_bit    = 1'($urandom);
      emb_rm     = 2'($urandom);
      glob_rm    = 2'($urandom);
      rsv_field  = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
      run_op("R3 R4 R6 R7 R8 R9 random");
    end

    summary();
  end

endmodule